// File: doc/BRIEF.md
# Serial Command Register Interface

This block lets a host processor load a small set of configuration registers over a three-wire serial link: a bit clock, a data line and a latch strobe. All three host lines are asynchronous to the system clock. The block synchronises each line into the system domain and finds its edges there. On each rising edge of the bit clock it shifts one data bit into a 12-bit word. A falling edge of the latch strobe decodes that word and updates the registers.

The word carries an 8-bit data field and then a 4-bit address field, and each field is sent least significant bit first. One address writes one of three 4-bit mute colour registers (red, green, blue). A second address sets or clears one bit of a 16-bit graphics channel enable mask. Every other address is reserved. The register values drive ports directly and change only when the strobe is decoded. The system clock must run at least four times faster than the highest serial bit rate (0.65 MHz).

Top module: `serial_cmd_if`

## Requirements
- R1: After reset, chan_en = 16'h0003 (channels 0 and 1 on), mute_red = 4'h0, mute_grn = 4'h0 and mute_blu = 4'hF.
- R2: A frame is 12 bits in this order: data bits D0..D7, then address bits A0..A3. The 12 bits most recently shifted form the word {A3..A0, D7..D0} that the latch decodes.
- R3: Address 4'hC writes the colour value D5..D2 into the register chosen by D7:D6, where 2'b00 is red, 2'b01 is green and 2'b10 is blue. The other two colour registers keep their values.
- R4: Address 4'hC with D7:D6 = 2'b11 changes none of the colour registers and does not change the mask.
- R5: Address 4'hD with D7 = 1 sets chan_en bit D3..D0 and leaves the other 15 bits unchanged.
- R6: Address 4'hD with D7 = 0 clears chan_en bit D3..D0 and leaves the other 15 bits unchanged.
- R7: Addresses other than 4'hC and 4'hD (4'h0..4'hB, 4'hE, 4'hF) change no output.
- R8: Outputs change only in response to a falling edge of ser_lat. Shifting bits without a latch leaves every output stable.
- R9: A latch that follows fewer than 12 new bits decodes the current contents of the shift register, which are the 12 most recently shifted bits. No bit counter gates the decode.
- R10: ser_dat is captured only at the rising edge of ser_clk. A change on ser_dat while ser_clk is high does not affect the captured bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ser_clk | input | 1 | Host serial bit clock; data is captured on its rising edge |
| ser_dat | input | 1 | Host serial data, LSB first |
| ser_lat | input | 1 | Host latch strobe; its falling edge decodes the word |
| chan_en | output | 16 | Graphics channel enable mask |
| mute_red | output | 4 | Mute colour, red component |
| mute_grn | output | 4 | Mute colour, green component |
| mute_blu | output | 4 | Mute colour, blue component |

## Verification
The bench sends full frames to every colour target. It checks that writing one colour leaves the other two alone. A design that decoded the select field in the wrong order, or placed the colour field at the wrong bit offset, would write the wrong register or the wrong value. The bench sets and clears mask bits at channels 0, 7 and 15, so an off-by-one index or a write that overwrites the whole mask shows up. It also sends the ignored select code and all 14 reserved addresses. The bench shifts a frame without latching it, so a design that updates on the shift rather than on the latch edge is caught. A short-frame latch must reuse the bits already held in the shift register, so a design that clears the register or counts bits gives a different mask. Finally, the bench toggles the data line while the bit clock is high, which exposes a design that samples at the wrong edge.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 4;
  localparam int FRAME_W  = DATA_W + ADDR_W;
  localparam int NUM_CH   = 16;
  localparam int CH_IDX_W = $clog2(NUM_CH);
  localparam int COL_W    = 4;
  localparam int COL_LSB  = 2;
  localparam int SEL_W    = 2;

  localparam logic [ADDR_W-1:0] ADDR_MUTE = 4'hC;
  localparam logic [ADDR_W-1:0] ADDR_CHAN = 4'hD;

  localparam logic [NUM_CH-1:0] CH_RESET  = 16'h0003;
  localparam logic [COL_W-1:0]  RED_RESET = 4'h0;
  localparam logic [COL_W-1:0]  GRN_RESET = 4'h0;
  localparam logic [COL_W-1:0]  BLU_RESET = 4'hF;

  typedef enum logic [SEL_W-1:0] {
    SEL_RED  = 2'b00,
    SEL_GRN  = 2'b01,
    SEL_BLU  = 2'b10,
    SEL_NONE = 2'b11
  } col_sel_e;

  // Address sits in the upper bits: it is shifted in last, entering at the MSB.
  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/scr_rst_sync.sv
module scr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/scr_sync.sv
module scr_sync #(
  parameter int LINES  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] async_in,
  output logic [LINES-1:0] level,
  output logic [LINES-1:0] rise,
  output logic [LINES-1:0] fall
);
  // One extra stage beyond the synchroniser holds the previous level for edge detection.
  localparam int DEPTH = STAGES + 1;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [DEPTH-1:0] pipe_q;
    logic [DEPTH-1:0] pipe_d;

    always_comb pipe_d = {pipe_q[DEPTH-2:0], async_in[g]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '0;
      else        pipe_q <= pipe_d;
    end

    assign level[g] = pipe_q[STAGES-1];
    assign rise[g]  =  pipe_q[STAGES-1] & ~pipe_q[STAGES];
    assign fall[g]  = ~pipe_q[STAGES-1] &  pipe_q[STAGES];
  end
endmodule

// File: rtl/scr_shift.sv
module scr_shift
  import scr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   shift_en,
  input  logic   bit_in,
  output frame_t word
);
  logic [FRAME_W-1:0] sr_q;
  logic [FRAME_W-1:0] sr_d;

  // The newest bit enters at the MSB, so the first bit sent ends up at bit 0.
  always_comb begin
    sr_d = sr_q;
    if (shift_en) sr_d = {bit_in, sr_q[FRAME_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign word = frame_t'(sr_q);
endmodule

// File: rtl/scr_regs.sv
module scr_regs
  import scr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  frame_t            word,
  output logic [NUM_CH-1:0] chan_en,
  output logic [COL_W-1:0]  col_red,
  output logic [COL_W-1:0]  col_grn,
  output logic [COL_W-1:0]  col_blu
);
  logic [NUM_CH-1:0] ch_q, ch_d;
  logic [COL_W-1:0]  red_q, red_d, grn_q, grn_d, blu_q, blu_d;

  col_sel_e          sel;
  logic [COL_W-1:0]  col_val;
  logic [CH_IDX_W-1:0] ch_idx;
  logic              ch_on;

  assign sel     = col_sel_e'(word.data[DATA_W-1 -: SEL_W]);
  assign col_val = word.data[COL_LSB +: COL_W];
  assign ch_idx  = word.data[CH_IDX_W-1:0];
  assign ch_on   = word.data[DATA_W-1];

  always_comb begin
    ch_d  = ch_q;
    red_d = red_q;
    grn_d = grn_q;
    blu_d = blu_q;
    if (load) begin
      unique case (word.addr)
        ADDR_MUTE: begin
          unique case (sel)
            SEL_RED:  red_d = col_val;
            SEL_GRN:  grn_d = col_val;
            SEL_BLU:  blu_d = col_val;
            SEL_NONE: ;
            default:  ;
          endcase
        end
        ADDR_CHAN: ch_d[ch_idx] = ch_on;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q  <= CH_RESET;
      red_q <= RED_RESET;
      grn_q <= GRN_RESET;
      blu_q <= BLU_RESET;
    end else if (load) begin
      ch_q  <= ch_d;
      red_q <= red_d;
      grn_q <= grn_d;
      blu_q <= blu_d;
    end
  end

  assign chan_en = ch_q;
  assign col_red = red_q;
  assign col_grn = grn_q;
  assign col_blu = blu_q;
endmodule

// File: rtl/serial_cmd_if.sv
module serial_cmd_if
  import scr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_lat,
  output logic [NUM_CH-1:0] chan_en,
  output logic [COL_W-1:0]  mute_red,
  output logic [COL_W-1:0]  mute_grn,
  output logic [COL_W-1:0]  mute_blu
);
  localparam int LINE_CLK = 0;
  localparam int LINE_DAT = 1;
  localparam int LINE_LAT = 2;
  localparam int N_LINES  = 3;

  logic               rst_n_int;
  logic [N_LINES-1:0] lvl, rise, fall;
  logic               bit_shift, bit_val, lat_fall;
  frame_t             sr_word;
  logic               unused_edges;

  scr_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_int)
  );

  scr_sync #(.LINES(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .async_in ({ser_lat, ser_dat, ser_clk}),
    .level    (lvl),
    .rise     (rise),
    .fall     (fall)
  );

  assign bit_shift = rise[LINE_CLK];
  assign bit_val   = lvl[LINE_DAT];
  assign lat_fall  = fall[LINE_LAT];
  assign unused_edges = ^{lvl[LINE_CLK], lvl[LINE_LAT], rise[LINE_DAT], rise[LINE_LAT],
                          fall[LINE_CLK], fall[LINE_DAT]};

  scr_shift u_shift (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .shift_en (bit_shift),
    .bit_in   (bit_val),
    .word     (sr_word)
  );

  scr_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .load    (lat_fall),
    .word    (sr_word),
    .chan_en (chan_en),
    .col_red (mute_red),
    .col_grn (mute_grn),
    .col_blu (mute_blu)
  );
endmodule

// File: rtl/scr_checker.sv
module scr_checker
  import scr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              lat_fall,
  input frame_t            word,
  input logic [NUM_CH-1:0] chan_en,
  input logic [COL_W-1:0]  mute_red,
  input logic [COL_W-1:0]  mute_grn,
  input logic [COL_W-1:0]  mute_blu
);
  logic is_mute, is_chan;
  assign is_mute = lat_fall && (word.addr == ADDR_MUTE);
  assign is_chan = lat_fall && (word.addr == ADDR_CHAN);

  a_r1_reset_values: assert property (@(posedge clk)
    !rst_n |=> (chan_en == CH_RESET && mute_red == RED_RESET &&
                mute_grn == GRN_RESET && mute_blu == BLU_RESET));

  a_r8_hold_without_latch: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_fall |=> ($stable(chan_en) && $stable(mute_red) && $stable(mute_grn) && $stable(mute_blu)));

  a_r7_reserved_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_fall && !is_mute && !is_chan) |=>
      ($stable(chan_en) && $stable(mute_red) && $stable(mute_grn) && $stable(mute_blu)));

  a_r3_red_write: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mute && word.data[7:6] == 2'b00) |=>
      (mute_red == $past(word.data[5:2]) && $stable(mute_grn) && $stable(mute_blu) && $stable(chan_en)));

  a_r4_select_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mute && word.data[7:6] == 2'b11) |=>
      ($stable(mute_red) && $stable(mute_grn) && $stable(mute_blu) && $stable(chan_en)));

  a_r5_channel_set: assert property (@(posedge clk) disable iff (!rst_n)
    (is_chan && word.data[7]) |=> chan_en[$past(word.data[3:0])]);

  a_r6_channel_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (is_chan && !word.data[7]) |=> !chan_en[$past(word.data[3:0])]);

  a_r6_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    is_chan |=> ($countones(chan_en ^ $past(chan_en)) <= 1));
endmodule

bind serial_cmd_if scr_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .lat_fall (lat_fall),
  .word     (sr_word),
  .chan_en  (chan_en),
  .mute_red (mute_red),
  .mute_grn (mute_grn),
  .mute_blu (mute_blu)
);

// File: tb/serial_cmd_if_bench.sv
`timescale 1ns/1ps
module serial_cmd_if_bench;
  logic clk = 1'b0;
  logic rst_n, ser_clk, ser_dat, ser_lat;
  logic [15:0] chan_en;
  logic [3:0]  mute_red, mute_grn, mute_blu;

  int checks = 0;
  int errors = 0;

  logic [11:0] model_sr = 12'h000;
  logic [15:0] exp_ch  = 16'h0003;
  logic [3:0]  exp_red = 4'h0, exp_grn = 4'h0, exp_blu = 4'hF;

  always #2.5 clk = ~clk;

  serial_cmd_if u_serial_cmd_if (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_lat(ser_lat),
    .chan_en(chan_en), .mute_red(mute_red), .mute_grn(mute_grn), .mute_blu(mute_blu)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " chan_en"},  chan_en,          exp_ch);
    chk({tag, " mute_red"}, {12'h0, mute_red}, {12'h0, exp_red});
    chk({tag, " mute_grn"}, {12'h0, mute_grn}, {12'h0, exp_grn});
    chk({tag, " mute_blu"}, {12'h0, mute_blu}, {12'h0, exp_blu});
  endtask

  // Expected decode, written from the requirements.
  task automatic apply_model(input logic [11:0] f);
    logic [3:0] a;
    logic [7:0] d;
    a = f[11:8];
    d = f[7:0];
    if (a == 4'hC) begin
      case (d[7:6])
        2'b00: exp_red = d[5:2];
        2'b01: exp_grn = d[5:2];
        2'b10: exp_blu = d[5:2];
        default: ;
      endcase
    end else if (a == 4'hD) begin
      exp_ch[d[3:0]] = d[7];
    end
  endtask

  task automatic send_bit(input logic b, input logic glitch);
    ser_dat = b;
    wait_n(4);
    ser_clk = 1'b1;
    wait_n(4);
    if (glitch) ser_dat = ~b;
    wait_n(4);
    ser_clk = 1'b0;
    wait_n(4);
    model_sr = {b, model_sr[11:1]};
  endtask

  task automatic send_frame(input logic [3:0] addr, input logic [7:0] data, input logic glitch);
    for (int i = 0; i < 8; i++) send_bit(data[i], glitch);
    for (int i = 0; i < 4; i++) send_bit(addr[i], glitch);
  endtask

  task automatic pulse_latch();
    ser_lat = 1'b0;
    wait_n(6);
    ser_lat = 1'b1;
    wait_n(6);
    apply_model(model_sr);
  endtask

  task automatic cmd(input logic [3:0] addr, input logic [7:0] data);
    send_frame(addr, data, 1'b0);
    pulse_latch();
  endtask

  task automatic t_reset();
    chk_all("R1 reset");
  endtask

  task automatic t_colour();
    cmd(4'hC, 8'h24);  chk_all("R2 R3 red=9");
    cmd(4'hC, 8'h54);  chk_all("R3 green=5");
    cmd(4'hC, 8'h8C);  chk_all("R3 blue=3");
    cmd(4'hC, 8'h3C);  chk_all("R3 red=F");
  endtask

  task automatic t_ignore_sel();
    cmd(4'hC, 8'hFC);  chk_all("R4 select 11");
    cmd(4'hC, 8'hC0);  chk_all("R4 select 11 zero");
  endtask

  task automatic t_channels();
    cmd(4'hD, 8'h8F);  chk_all("R5 set ch15");
    cmd(4'hD, 8'h87);  chk_all("R5 set ch7");
    cmd(4'hD, 8'h00);  chk_all("R6 clear ch0");
    cmd(4'hD, 8'h0F);  chk_all("R6 clear ch15");
    cmd(4'hD, 8'h01);  chk_all("R6 clear ch1");
  endtask

  task automatic t_reserved();
    for (int a = 0; a < 16; a++) begin
      if (a != 12 && a != 13) begin
        cmd(4'(a), (a % 2 == 0) ? 8'hFF : 8'h00);
        chk_all($sformatf("R7 reserved addr %0h", a));
      end
    end
  endtask

  task automatic t_no_latch();
    send_frame(4'hD, 8'h83, 1'b0);
    wait_n(10);
    chk_all("R8 shifted, not latched");
    pulse_latch();
    chk_all("R8 after latch set ch3");
  endtask

  task automatic t_short();
    cmd(4'hD, 8'h8A);
    chk_all("R9 full frame ch10");
    send_bit(1'b1, 1'b0);
    send_bit(1'b0, 1'b0);
    send_bit(1'b1, 1'b0);
    send_bit(1'b1, 1'b0);
    pulse_latch();
    chk("R9 short frame sets ch8", {15'h0, chan_en[8]}, 16'h0001);
    chk_all("R9 short frame");
  endtask

  task automatic t_glitch();
    send_frame(4'hC, 8'h68, 1'b1);
    pulse_latch();
    chk_all("R10 data toggled while clock high");
  endtask

  initial begin
    rst_n = 1'b0; ser_clk = 1'b0; ser_dat = 1'b0; ser_lat = 1'b1;
    wait_n(4);
    rst_n = 1'b1;
    wait_n(6);
    t_reset();
    t_colour();
    t_ignore_sel();
    t_channels();
    t_reserved();
    t_no_latch();
    t_short();
    t_glitch();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(100000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule